// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block controls a small group of general-purpose pins through three registers reached over a simple read/write bus. A direction register picks, pin by pin, whether the pin drives or listens. A level register has two uses: on a driving pin it sets the level put on the pad, and on a listening pin it decides whether a weak pull-up is switched on or the pin is left floating. A third register is read-only and returns the pad levels after they have passed through a two-flop synchronizer.

Toward the pads the block gives each pin an output enable, an output value and a pull-up enable, and it takes the raw pad level back in. Reads are combinational on the current address. Writes take effect at the clock edge on which the write strobe is high. Reset is asynchronous and active low. It leaves every pin as a floating input.

Top module: `gpio_port`

## Requirements
- R1: While reset is held and right after it, the direction and level registers read 0, and the enable, output value and pull-up signals of every pin are 0.
- R2: A write to address 0 loads the direction register (bit i = 1 makes pin i drive, 0 makes it an input). A read of address 0 returns the stored value.
- R3: A write to address 1 loads the level register. A read of address 1 returns the stored value.
- R4: The output enable of each pin equals its direction bit from the clock edge after the write.
- R5: On a driving pin the output value equals its level bit (1 = high). On an input pin the output value is 0.
- R6: The pull-up of a pin is on only when the pin is an input and its level bit is 1. An input pin with level bit 0 floats, and a driving pin never has its pull-up on.
- R7: A read of address 2 returns the pad levels as they were two clock edges earlier, whatever each pin's direction.
- R8: A write to address 2 changes neither the direction register nor the level register.
- R9: Address 3 reads as 0, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Write strobe, sampled at the rising edge |
| busWdata | input | NPINS | Write data |
| busRdata | output | NPINS | Read data for the current address |
| padIn | input | NPINS | Raw pad levels |
| padOe | output | NPINS | Per-pin output enable |
| padOut | output | NPINS | Per-pin driven level |
| padPullUp | output | NPINS | Per-pin weak pull-up enable |

## Verification
The assertions check on every cycle that a driving pin never has its pull-up on, that writes to the direction and level addresses show up on the pad controls one edge later, that writes to addresses 2 and 3 leave the pad controls unchanged, and that the input register lags the pads by exactly two edges. The bench's scenarios are needed to show the full register readback, the reset values, and the combined effect of both registers across mixed pin directions. These come from directed cases and a long seeded random sequence compared against a bench model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DIR   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PINS  = 2'd2;

  typedef enum logic [1:0] {
    SEL_DIR   = 2'd0,
    SEL_LEVEL = 2'd1,
    SEL_PINS  = 2'd2,
    SEL_NONE  = 2'd3
  } readSel_e;

  typedef struct packed {
    logic     dirWe;
    logic     levelWe;
    readSel_e rdSel;
  } portStrobes_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output portStrobes_t      strobes
);

  always_comb begin
    strobes = '{dirWe: 1'b0, levelWe: 1'b0, rdSel: SEL_NONE};
    unique case (busAddr)
      ADDR_DIR: begin
        strobes.dirWe = busWr;
        strobes.rdSel = SEL_DIR;
      end
      ADDR_LEVEL: begin
        strobes.levelWe = busWr;
        strobes.rdSel   = SEL_LEVEL;
      end
      ADDR_PINS: begin
        strobes.rdSel = SEL_PINS;
      end
      default: begin
        strobes.rdSel = SEL_NONE;
      end
    endcase
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobes_t     strobes,
  input  logic [NPINS-1:0] busWdata,
  output logic [NPINS-1:0] busRdata,
  input  logic [NPINS-1:0] padIn,
  output logic [NPINS-1:0] padOe,
  output logic [NPINS-1:0] padOut,
  output logic [NPINS-1:0] padPullUp
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NPINS-1:0] dirReg;
  logic [NPINS-1:0] levelReg;
  logic [NPINS-1:0] syncStage [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
    end else if (strobes.dirWe) begin
      dirReg <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelReg <= '0;
    end else if (strobes.levelWe) begin
      levelReg <= busWdata;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncStage[s] <= '0;
        end else if (s == 0) begin
          syncStage[s] <= padIn;
        end else begin
          syncStage[s] <= syncStage[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      always_comb begin
        padOe[p]     = dirReg[p];
        padOut[p]    = dirReg[p] & levelReg[p];
        padPullUp[p] = ~dirReg[p] & levelReg[p];
      end
    end
  endgenerate

  always_comb begin
    unique case (strobes.rdSel)
      SEL_DIR:   busRdata = dirReg;
      SEL_LEVEL: busRdata = levelReg;
      SEL_PINS:  busRdata = syncStage[LAST];
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [NPINS-1:0]  busWdata,
  output logic [NPINS-1:0]  busRdata,
  input  logic [NPINS-1:0]  padIn,
  output logic [NPINS-1:0]  padOe,
  output logic [NPINS-1:0]  padOut,
  output logic [NPINS-1:0]  padPullUp
);

  portStrobes_t strobes;

  gpio_port_ctrl i_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobes (strobes)
  );

  gpio_port_dp #(
    .NPINS       (NPINS),
    .SYNC_STAGES (2)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .padPullUp (padPullUp)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       busAddr,
  input logic             busWr,
  input logic [NPINS-1:0] busWdata,
  input logic [NPINS-1:0] busRdata,
  input logic [NPINS-1:0] padIn,
  input logic [NPINS-1:0] padOe,
  input logic [NPINS-1:0] padOut,
  input logic [NPINS-1:0] padPullUp
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |-> (padOe == '0 && padOut == '0 && padPullUp == '0));

  // R4
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd0) |=> (padOe == $past(busWdata)));

  // R5
  level_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd1) |=> ((padOut & padOe) == ($past(busWdata) & padOe)));

  // R6
  no_pull_on_driver_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padPullUp) == '0);

  // R8
  pins_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd2) |=> ($stable(padOe) && $stable(padOut) && $stable(padPullUp)));

  // R9
  hole_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd3) |=> ($stable(padOe) && $stable(padOut) && $stable(padPullUp)));

  // R9
  hole_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> (busRdata == '0));

  // R7
  pin_sample_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && busAddr == 2'd2) |-> (busRdata == $past(padIn, 2)));

endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS)) i_chk (.*);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;

  localparam int NPINS = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       busAddr = '0;
  logic             busWr = 1'b0;
  logic [NPINS-1:0] busWdata = '0;
  logic [NPINS-1:0] busRdata;
  logic [NPINS-1:0] padIn = '0;
  logic [NPINS-1:0] padOe;
  logic [NPINS-1:0] padOut;
  logic [NPINS-1:0] padPullUp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [NPINS-1:0] expDir = '0;
  logic [NPINS-1:0] expLevel = '0;
  logic [NPINS-1:0] hist1 = '0;
  logic [NPINS-1:0] hist2 = '0;

  always #2 clk = ~clk;

  gpio_port #(.NPINS(NPINS)) i_gpio_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .padPullUp(padPullUp)
  );

  // Bench model of the two-edge pad delay
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist1 <= '0;
      hist2 <= '0;
    end else begin
      hist2 <= hist1;
      hist1 <= padIn;
    end
  end

  function automatic logic [NPINS-1:0] modelOut(input logic [NPINS-1:0] d, input logic [NPINS-1:0] l);
    return d & l;
  endfunction

  function automatic logic [NPINS-1:0] modelPull(input logic [NPINS-1:0] d, input logic [NPINS-1:0] l);
    return ~d & l;
  endfunction

  task automatic check(input string req, input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [NPINS-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    if (a == 2'd0) expDir = d;
    else if (a == 2'd1) expLevel = d;
  endtask

  task automatic readCheck(input logic [1:0] a, input string req);
    logic [NPINS-1:0] exp;
    busAddr = a;
    #0.5;
    case (a)
      2'd0: exp = expDir;
      2'd1: exp = expLevel;
      2'd2: exp = hist2;
      default: exp = '0;
    endcase
    check(req, busRdata, exp);
  endtask

  task automatic padCheck();
    check("R4 padOe", padOe, expDir);
    check("R5 padOut", padOut, modelOut(expDir, expLevel));
    check("R6 padPullUp", padPullUp, modelPull(expDir, expLevel));
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 reset state
    padIn = 8'hA5;
    repeat (3) @(negedge clk);
    check("R1 padOe", padOe, '0);
    check("R1 padOut", padOut, '0);
    check("R1 padPullUp", padPullUp, '0);
    rstN = 1'b1;
    @(negedge clk);
    readCheck(2'd0, "R1 dir reset");
    readCheck(2'd1, "R1 level reset");

    // R2 R3 directed writes and readback
    writeReg(2'd0, 8'h0F);
    readCheck(2'd0, "R2 dir readback");
    writeReg(2'd1, 8'h33);
    readCheck(2'd1, "R3 level readback");
    padCheck();
    // R6 all inputs with pull-ups
    writeReg(2'd0, 8'h00);
    writeReg(2'd1, 8'hFF);
    check("R6 all pulled", padPullUp, 8'hFF);
    check("R5 inputs drive 0", padOut, 8'h00);
    // R5 all outputs high
    writeReg(2'd0, 8'hFF);
    check("R5 all high", padOut, 8'hFF);
    check("R6 no pull on drivers", padPullUp, 8'h00);

    // R8 write to input register ignored
    writeReg(2'd2, 8'h00);
    readCheck(2'd0, "R8 dir kept");
    readCheck(2'd1, "R8 level kept");
    padCheck();
    // R9 hole address
    writeReg(2'd3, 8'h5A);
    readCheck(2'd3, "R9 reads zero");
    readCheck(2'd0, "R9 dir kept");
    readCheck(2'd1, "R9 level kept");

    // R7 pad sampling lag, with driving pins
    @(negedge clk); padIn = 8'h3C;
    @(negedge clk);
    readCheck(2'd2, "R7 one edge");
    @(negedge clk);
    readCheck(2'd2, "R7 two edges");
    check("R7 value", busRdata, 8'h3C);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 5);
      logic [NPINS-1:0] v = NPINS'($urandom);
      @(negedge clk);
      padIn = NPINS'($urandom);
      case (op)
        0: writeReg(2'd0, v);
        1: writeReg(2'd1, v);
        2: writeReg(2'd2, v);
        3: writeReg(2'd3, v);
        default: @(negedge clk);
      endcase
      padCheck();
      readCheck(2'($urandom_range(0, 3)), "R2 R3 R7 R9 random read");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule